// File: doc/BRIEF.md
# Three-Sample Debounce Filter

This block cleans up a single noisy bit that has already been synchronised to the local clock. It is built as a Moore machine with six named states. Each state holds two things: the level currently accepted as true, and how many opposite samples have been seen in a row. The filtered output moves to a new level only when that level has appeared on three consecutive sampled ticks. Any shorter burst is ignored.

Sampling is paced by a strobe. On a clock edge where the strobe is low, nothing changes, so a slow tick can stretch the filter window without a wide counter. Reset is synchronous and active high, and it places the machine at a confirmed high level. The current state is brought out so that a debug view can watch the run length build up.

Top module: `debounce3_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is confirmed high: `filt_out` = 1 and `dbg_state` = 3'b100.
- R2: From confirmed high, three enabled samples of 0 in a row make `filt_out` 0 right after the edge that takes the third 0. After only one or two such samples, `filt_out` is still 1.
- R3: From confirmed low, three enabled samples of 1 in a row make `filt_out` 1 right after the edge that takes the third 1. After only one or two such samples, `filt_out` is still 0.
- R4: A sample equal to the confirmed level, taken while a run of opposite samples is partly built, clears the run to zero and leaves the output unchanged.
- R5: On an edge where `smp_en` is low, `dbg_state` and `filt_out` keep their values whatever `raw_in` is. A run is counted over enabled samples only, so idle cycles between them do not break it.
- R6: `dbg_state[2]` is the confirmed level. `dbg_state[1:0]` is the count of consecutive opposite samples, from 0 to 2. The value 2'b11 never appears in that field.
- R7: Start from reset and feed the enabled sample sequence 1 0 0 1 0 1 0 0 0 1 0 1 1 1. The output after each sample is then 1 1 1 1 1 1 1 1 0 0 0 0 0 1.
- R8: `filt_out` always equals the level of the current state (`dbg_state[2]`). It never lags the state by a cycle.
- R9: Reset takes priority over `smp_en`. With both high and `raw_in` = 0, the machine stays at confirmed high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe; `raw_in` is consumed only on edges where this is high |
| raw_in | input | 1 | Synchronised raw input bit |
| filt_out | output | 1 | Debounced level |
| dbg_state | output | 3 | Current state: bit 2 is the level, bits 1:0 are the opposite-run count |

## Verification
Every result is due one clock edge after the enabled sample that causes it. The state register is the only storage on the path, and `filt_out` is decoded from it with no further register. The bench drives `raw_in` and `smp_en` on the falling edge and lets the rising edge consume them. It compares `filt_out` and `dbg_state` one time unit after that rising edge with values from its own level and run model. For R5, the bench clears the strobe for a number of cycles while toggling `raw_in`, and checks both outputs after every one of those edges.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

    localparam int unsigned RUN_LEN   = 3;
    localparam int unsigned RUN_W     = 2;
    localparam int unsigned STATE_W   = RUN_W + 1;

    // bit 2: confirmed level, bits 1:0: opposite-sample run length
    typedef enum logic [STATE_W-1:0] {
        ST_LO_STEADY = 3'b000,
        ST_LO_SAW1   = 3'b001,
        ST_LO_SAW11  = 3'b010,
        ST_HI_STEADY = 3'b100,
        ST_HI_SAW0   = 3'b101,
        ST_HI_SAW00  = 3'b110
    } dbn_state_e;

    typedef struct packed {
        logic             level;
        logic [RUN_W-1:0] run;
    } dbn_view_t;

    localparam dbn_state_e RESET_STATE = ST_HI_STEADY;

    function automatic dbn_view_t dbn_split(input logic [STATE_W-1:0] code);
        dbn_view_t v;
        v.level = code[STATE_W-1];
        v.run   = code[RUN_W-1:0];
        return v;
    endfunction

    function automatic logic dbn_is_legal(input logic [STATE_W-1:0] code);
        dbn_view_t v;
        v = dbn_split(code);
        return (v.run < RUN_W'(RUN_LEN - 1)) || (v.run == RUN_W'(RUN_LEN - 1));
    endfunction

    function automatic logic [STATE_W-1:0] dbn_step(input logic [STATE_W-1:0] code,
                                                    input logic sample);
        dbn_view_t cur;
        dbn_view_t nxt;
        cur = dbn_split(code);
        if (!dbn_is_legal(code)) begin
            nxt = dbn_split(RESET_STATE);
        end else if (sample == cur.level) begin
            nxt.level = cur.level;
            nxt.run   = '0;
        end else if (cur.run == RUN_W'(RUN_LEN - 1)) begin
            nxt.level = ~cur.level;
            nxt.run   = '0;
        end else begin
            nxt.level = cur.level;
            nxt.run   = cur.run + RUN_W'(1);
        end
        return nxt;
    endfunction

endpackage

// File: rtl/dbn_step_logic.sv
module dbn_step_logic
    import dbn_pkg::*;
(
    input  logic [STATE_W-1:0] cur_state,
    input  logic               sample,
    output logic [STATE_W-1:0] nxt_state
);

    always_comb begin
        nxt_state = dbn_step(cur_state, sample);
    end

endmodule

// File: rtl/dbn_state_reg.sv
module dbn_state_reg
    import dbn_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [STATE_W-1:0] d,
    output logic [STATE_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_STATE;
        end else if (load) begin
            q <= d;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (q == RESET_STATE)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q)); // R5

endmodule

// File: rtl/dbn_out_dec.sv
module dbn_out_dec
    import dbn_pkg::*;
(
    input  logic [STATE_W-1:0] state,
    output logic               level
);

    dbn_view_t v;

    always_comb begin
        v = dbn_split(state);
        if (dbn_is_legal(state)) begin
            level = v.level;
        end else begin
            level = dbn_split(RESET_STATE).level;
        end
    end

endmodule

// File: rtl/debounce3_filter.sv
module debounce3_filter
    import dbn_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       smp_en,
    input  logic       raw_in,
    output logic       filt_out,
    output logic [2:0] dbg_state
);

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;
    dbn_view_t          cur_v;

    dbn_step_logic u_step (
        .cur_state (state_q),
        .sample    (raw_in),
        .nxt_state (state_d)
    );

    dbn_state_reg u_reg (
        .clk  (clk),
        .rst  (rst),
        .load (smp_en),
        .d    (state_d),
        .q    (state_q)
    );

    dbn_out_dec u_dec (
        .state (state_q),
        .level (filt_out)
    );

    assign dbg_state = state_q;

    always_comb begin
        cur_v = dbn_split(state_q);
    end

    AST_RUN_FIELD_OK: assert property (@(posedge clk) disable iff (rst)
        cur_v.run != 2'b11); // R6

    AST_OUT_IS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        filt_out == cur_v.level); // R8

    AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (smp_en && raw_in == cur_v.level) |=> (cur_v.run == 2'b00 && $stable(filt_out))); // R4

    AST_RUN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (smp_en && raw_in != cur_v.level && cur_v.run != 2'b10)
        |=> (cur_v.run == $past(cur_v.run) + 2'b01 && $stable(filt_out))); // R6

    AST_FLIP_ON_THIRD: assert property (@(posedge clk) disable iff (rst)
        (smp_en && raw_in != cur_v.level && cur_v.run == 2'b10)
        |=> (filt_out == $past(raw_in) && cur_v.run == 2'b00)); // R2

endmodule

// File: tb/sim_debounce3_filter.sv
module sim_debounce3_filter;

    logic       clk = 1'b0;
    logic       rst;
    logic       smp_en;
    logic       raw_in;
    logic       filt_out;
    logic [2:0] dbg_state;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic       mdl_level;
    logic [1:0] mdl_run;

    always #2 clk = ~clk;

    debounce3_filter u0 (
        .clk       (clk),
        .rst       (rst),
        .smp_en    (smp_en),
        .raw_in    (raw_in),
        .filt_out  (filt_out),
        .dbg_state (dbg_state)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_model(input string req);
        chk({req, " out"},   {3'b0, filt_out}, {3'b0, mdl_level});
        chk({req, " state"}, {1'b0, dbg_state}, {1'b0, mdl_level, mdl_run});
    endtask

    // independent model: count opposite samples, flip at three
    task automatic push(input logic v);
        @(negedge clk);
        raw_in = v;
        smp_en = 1'b1;
        @(posedge clk);
        #1;
        smp_en = 1'b0;
        if (v == mdl_level) begin
            mdl_run = 2'd0;
        end else if (mdl_run == 2'd2) begin
            mdl_level = v;
            mdl_run   = 2'd0;
        end else begin
            mdl_run = mdl_run + 2'd1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst    = 1'b1;
        smp_en = 1'b1;
        raw_in = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        mdl_level = 1'b1;
        mdl_run   = 2'd0;
        chk("R9 reset beats enable out", {3'b0, filt_out}, 4'h1);
        @(negedge clk);
        rst    = 1'b0;
        smp_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset out",   {3'b0, filt_out}, 4'h1);
        chk("R1 reset state", {1'b0, dbg_state}, 4'h4);
    endtask

    task automatic t_reference();
        logic [13:0] seq_in;
        logic [13:0] seq_out;
        seq_in  = 14'b10010100010111;
        seq_out = 14'b11111111000001;
        do_reset();
        for (int i = 13; i >= 0; i--) begin
            push(seq_in[i]);
            chk("R7 reference out", {3'b0, filt_out}, {3'b0, seq_out[i]});
            chk("R8 out matches state level", {3'b0, filt_out}, {3'b0, dbg_state[2]});
            chk_model("R6 reference");
        end
    endtask

    task automatic t_fall();
        do_reset();
        push(1'b0); chk_model("R2 one zero");
        push(1'b0); chk_model("R2 two zeros");
        chk("R2 two zeros hold high", {3'b0, filt_out}, 4'h1);
        push(1'b0);
        chk("R2 third zero flips", {3'b0, filt_out}, 4'h0);
        chk("R6 low steady code", {1'b0, dbg_state}, 4'h0);
    endtask

    task automatic t_rise();
        // continues from confirmed low left by t_fall
        push(1'b1); chk_model("R3 one one");
        push(1'b1);
        chk("R3 two ones hold low", {3'b0, filt_out}, 4'h0);
        chk("R6 two ones code", {1'b0, dbg_state}, 4'h2);
        push(1'b1);
        chk("R3 third one flips", {3'b0, filt_out}, 4'h1);
        chk_model("R3 high again");
    endtask

    task automatic t_interrupt();
        do_reset();
        push(1'b0); push(1'b0); push(1'b1);
        chk("R4 run cleared state", {1'b0, dbg_state}, 4'h4);
        chk("R4 output held", {3'b0, filt_out}, 4'h1);
        push(1'b0); push(1'b0);
        chk("R4 restarted run holds", {3'b0, filt_out}, 4'h1);
        push(1'b0);
        chk("R4 full run flips", {3'b0, filt_out}, 4'h0);
        push(1'b1); push(1'b0);
        chk("R4 low side cleared", {1'b0, dbg_state}, 4'h0);
    endtask

    task automatic t_enable();
        logic [2:0] held;
        do_reset();
        push(1'b0);
        held = dbg_state;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            raw_in = i[0];
            smp_en = 1'b0;
            @(posedge clk);
            #1;
            chk("R5 idle state held", {1'b0, dbg_state}, {1'b0, held});
            chk("R5 idle out held", {3'b0, filt_out}, 4'h1);
        end
        push(1'b0);
        repeat (5) @(posedge clk);
        push(1'b0);
        chk("R5 gapped run completes", {3'b0, filt_out}, 4'h0);
        chk_model("R5 gapped run");
    endtask

    initial begin
        rst    = 1'b1;
        smp_en = 1'b0;
        raw_in = 1'b1;
        mdl_level = 1'b1;
        mdl_run   = 2'd0;
        t_reset();
        t_reference();
        t_fall();
        t_rise();
        t_interrupt();
        t_enable();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule